// File: doc/BRIEF.md
# Serial NOR Flash Page Writer

This block writes a run of 256-byte pages into a serial NOR flash device. A request gives a flash start address and a byte count. Both must be whole pages. The block fetches the new bytes from a local buffer through an address/data port, where the buffer address equals the flash byte address. It reaches the flash through a byte-exchange handshake that sits on top of an SPI shifter, plus a chip-select line that the block controls.

Pages are handled from the highest address down to the start address. For each page the engine reads back the stored bytes and compares them with the buffer. A page that already matches is left alone. Any other page goes through this sequence:

1. Write enable, as its own transaction.
2. Status polling until the enable latch shows as set.
3. A page program transaction.
4. Status polling until the busy bit clears.
5. A read-back check against the buffer.

The first failed check, or a poll loop that runs too long, ends the request with a failure. The outcome is reported as a one-cycle done pulse with a pass bit.

Top module: `spi_page_writer`

## Requirements
- R1: A request whose address or length has any of bits [7:0] set finishes with done=1 and pass=0, and chip-select never goes low.
- R2: A request with length zero finishes with done=1 and pass=1 and runs no transaction.
- R3: A read transaction sends 0x03, then the 24-bit page address most significant byte first, then 256 bytes of 0x00 while collecting data. Each page's first transaction is such a read.
- R4: A page whose stored bytes all equal the buffer counts as complete, and no 0x06 or 0x02 transaction is sent for it.
- R5: Before programming, 0x06 is sent as a one-byte transaction. A separate transaction then sends 0x05 and keeps reading status bytes until bit 1 reads 1.
- R6: A program transaction sends 0x02, the 24-bit address most significant byte first, and exactly 256 bytes. Byte k is the buffer value at page address + k.
- R7: After programming, a 0x05 transaction polls until status bit 0 reads 0. The page is then read back. Any difference ends the request with pass=0, and lower pages are not programmed.
- R8: Pages are processed from start+length-256 down to start, one page step at a time.
- R9: pass=1 is reported only after every page of the request has completed.
- R10: Chip-select stays low for every byte of a transaction and is high for at least one cycle between transactions. A byte request holds its value until acknowledged.
- R11: A status poll that reads POLL_LIMIT bytes without the awaited bit value ends the request with pass=0. No read-back follows.
- R12: done is high for exactly one cycle per request, and busy is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (accepted when idle) |
| req_addr | input | 24 | Flash start byte address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Outcome, valid with done |
| buf_addr | output | 24 | Buffer byte address (equals flash address) |
| buf_data | input | 8 | Buffer byte at buf_addr, same cycle |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| xfer_req | output | 1 | Byte exchange request |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Byte exchange complete |
| xfer_rx | input | 8 | Byte shifted in, valid with xfer_ack |

## Verification
A behavioural flash model answers the exchange handshake and delays both the enable latch and the busy bit by several status reads, so both poll loops iterate more than once.

- A single page at a high address with many set bits checks the command bytes, address byte order and transaction lengths.
- A sweep over every start page and page count in a four-page window shows that the program order is descending and that the write count equals the page count.
- Rewriting unchanged data, and changing a single byte, separates a page that is skipped from one that is programmed.
- An injected program corruption and a stuck busy bit separate the verify failure from the poll timeout. The count of transactions shows which pages were left untouched.

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int LEN_W      = 25,
  parameter int POLL_LIMIT = 100000,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_STAT = 8'h05,
  parameter logic [7:0] OP_PROG = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [23:0]      buf_addr,
  input  logic [7:0]       buf_data,
  output logic             spi_cs_n,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [8:0] LAST_BYTE = 9'd259;
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(256);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_NEXT, S_GAP} st_t;
  typedef enum logic [2:0] {P_RD, P_WREN, P_WEL, P_PROG, P_WIP, P_VFY} ph_t;

  st_t              st;
  ph_t              ph;
  logic [8:0]       cnt;
  logic [23:0]      page;
  logic [LEN_W-1:0] remain;
  logic             diff, bad;
  logic [POLL_W-1:0] polls;

  logic       addressed, is_poll, rd_phase, poll_hit, poll_fail, tx_end, mism;
  logic [8:0] didx;
  logic [7:0] opcode;

  assign addressed = (ph == P_RD) || (ph == P_PROG) || (ph == P_VFY);
  assign rd_phase  = (ph == P_RD) || (ph == P_VFY);
  assign is_poll   = (ph == P_WEL) || (ph == P_WIP);
  assign didx      = cnt - 9'd4;
  assign buf_addr  = {page[23:8], didx[7:0]};

  assign busy     = (st != S_IDLE);
  assign xfer_req = (st == S_XFER);
  assign spi_cs_n = !((st == S_XFER) || (st == S_NEXT));

  always_comb begin
    case (ph)
      P_RD, P_VFY:   opcode = OP_READ;
      P_WREN:        opcode = OP_WREN;
      P_PROG:        opcode = OP_PROG;
      default:       opcode = OP_STAT;
    endcase
  end

  always_comb begin
    if (cnt == 9'd0)                   xfer_tx = opcode;
    else if (addressed && cnt == 9'd1) xfer_tx = page[23:16];
    else if (addressed && cnt == 9'd2) xfer_tx = page[15:8];
    else if (addressed && cnt == 9'd3) xfer_tx = page[7:0];
    else if (ph == P_PROG)             xfer_tx = buf_data;
    else                               xfer_tx = 8'h00;
  end

  assign poll_hit  = (ph == P_WEL) ? xfer_rx[1] : !xfer_rx[0];
  assign poll_fail = is_poll && (cnt != 9'd0) && !poll_hit &&
                     (polls == POLL_W'(POLL_LIMIT - 1));
  assign mism      = rd_phase && (cnt >= 9'd4) && (xfer_rx != buf_data);

  always_comb begin
    if (ph == P_WREN)  tx_end = 1'b1;
    else if (is_poll)  tx_end = (cnt != 9'd0) && (poll_hit || poll_fail);
    else               tx_end = (cnt == LAST_BYTE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= P_RD;
      cnt    <= '0;
      page   <= '0;
      remain <= '0;
      diff   <= 1'b0;
      bad    <= 1'b0;
      polls  <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_addr[7:0] != 8'd0 || req_len[7:0] != 8'd0) begin
            done <= 1'b1;
            pass <= 1'b0;
          end else if (req_len == '0) begin
            done   <= 1'b1;
            pass   <= 1'b1;
            remain <= '0;
          end else begin
            page   <= req_addr + req_len[23:0] - 24'd256;
            remain <= req_len;
            ph     <= P_RD;
            cnt    <= '0;
            polls  <= '0;
            diff   <= 1'b0;
            bad    <= 1'b0;
            st     <= S_XFER;
          end
        end
        S_XFER: if (xfer_ack) begin
          if (mism) diff <= 1'b1;
          if (is_poll && cnt != 9'd0) polls <= polls + 1'b1;
          if (poll_fail) bad <= 1'b1;
          if (tx_end) st <= S_GAP;
          else begin
            st  <= S_NEXT;
            cnt <= (is_poll && cnt != 9'd0) ? cnt : cnt + 9'd1;
          end
        end
        S_NEXT: st <= S_XFER;
        default: begin
          cnt   <= '0;
          polls <= '0;
          diff  <= 1'b0;
          st    <= S_XFER;
          if (bad) begin
            st   <= S_IDLE;
            done <= 1'b1;
            pass <= 1'b0;
          end else begin
            case (ph)
              P_WREN: ph <= P_WEL;
              P_WEL:  ph <= P_PROG;
              P_PROG: ph <= P_WIP;
              P_WIP:  ph <= P_VFY;
              default: begin
                if (ph == P_RD && diff) ph <= P_WREN;
                else if (ph == P_VFY && diff) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                  pass <= 1'b0;
                end else begin
                  remain <= remain - PAGE_LEN;
                  ph     <= P_RD;
                  if (remain == PAGE_LEN) begin
                    st   <= S_IDLE;
                    done <= 1'b1;
                    pass <= 1'b1;
                  end else begin
                    page <= page - 24'd256;
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_addr[7:0] != 8'd0 || req_len[7:0] != 8'd0))
      |=> (done && !pass && spi_cs_n));

  assert_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !spi_cs_n);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  assert_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> xfer_req);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_pass_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (remain == '0));
endmodule

// File: tb/spi_page_writer_test.sv
module spi_page_writer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, busy, done, pass;
  logic [23:0] req_addr, buf_addr;
  logic [24:0] req_len;
  logic [7:0]  buf_data, xfer_tx, xfer_rx;
  logic        spi_cs_n, xfer_req, xfer_ack;

  logic [7:0]  src [0:1023];
  assign buf_data = src[buf_addr[9:0]];

  spi_page_writer #(.LEN_W(25), .POLL_LIMIT(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .done(done), .pass(pass),
    .buf_addr(buf_addr), .buf_data(buf_data), .spi_cs_n(spi_cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx));

  // behavioural flash
  logic [7:0]  mem [0:1023];
  logic [7:0]  pbuf [0:255];
  logic [7:0]  cmd;
  logic [23:0] maddr;
  logic        in_tx, wel, wip;
  int          bi, wel_wait, wip_left;
  int          tx_n, pp_n, dummy_bad, frame_bad;
  logic [7:0]  log_cmd [0:1023];
  logic [23:0] log_addr [0:1023];
  int          log_len [0:1023];
  logic [23:0] pp_log [0:255];
  logic        corrupt_on, stuck_on;
  logic [23:0] corrupt_page;

  task automatic exchange(input logic [7:0] b);
    logic [7:0] r;
    r = 8'hFF;
    if (bi == 0) cmd = b;
    else if ((cmd == 8'h03 || cmd == 8'h02) && bi <= 3) maddr = {maddr[15:0], b};
    else if (cmd == 8'h03) begin
      r = mem[(int'(maddr[9:0]) + bi - 4) % 1024];
      if (b != 8'h00) dummy_bad++;
    end else if (cmd == 8'h02) begin
      if (bi - 4 < 256) pbuf[bi-4] = b;
    end else if (cmd == 8'h05) begin
      r = {6'd0, wel && (wel_wait == 0), wip};
      if (wel_wait > 0) wel_wait--;
      if (wip) begin
        if (wip_left > 0) wip_left--;
        if (wip_left == 0 && !stuck_on) wip = 1'b0;
      end
    end
    xfer_rx = r;
    bi++;
  endtask

  task automatic finish_tx();
    log_cmd[tx_n % 1024]  = cmd;
    log_addr[tx_n % 1024] = maddr;
    log_len[tx_n % 1024]  = bi;
    tx_n++;
    if (cmd == 8'h06 && bi == 1) begin
      wel = 1'b1;
      wel_wait = 2;
    end
    if (cmd == 8'h02 && bi == 260 && wel) begin
      for (int k = 0; k < 256; k++) mem[{maddr[9:8], 8'(k)}] = pbuf[k];
      if (corrupt_on && maddr == corrupt_page) mem[{maddr[9:8], 8'd5}] ^= 8'h5A;
      pp_log[pp_n % 256] = maddr;
      pp_n++;
      wel = 1'b0;
      wip = 1'b1;
      wip_left = 3;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 1024; k++) mem[k] = 8'hFF;
      in_tx = 0; bi = 0; wel = 0; wip = 0; wel_wait = 0; wip_left = 0;
      tx_n = 0; pp_n = 0; dummy_bad = 0; frame_bad = 0;
      cmd = 0; maddr = 0; xfer_ack = 0; xfer_rx = 0;
    end else begin
      if (xfer_req && spi_cs_n) frame_bad++;
      if (spi_cs_n) begin
        if (in_tx) finish_tx();
        in_tx = 0; bi = 0; xfer_ack = 0;
      end else begin
        in_tx = 1;
        if (xfer_req && !xfer_ack) begin
          exchange(xfer_tx);
          xfer_ack = 1;
        end else xfer_ack = 0;
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  int pulse_bad = 0, busy_bad = 0;

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] val(input int i, input int seed);
    return 8'(i * 13 + seed * 29 + (i >> 8));
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) src[i] = val(i, seed);
  endtask

  task automatic run(input logic [23:0] a, input logic [24:0] l, output bit got, output bit seen);
    @(negedge clk);
    req_addr = a; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0; got = 0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      if (done) begin
        seen = 1; got = pass;
        if (busy) busy_bad++;
      end else @(negedge clk);
    end
    @(negedge clk);
    if (done) pulse_bad++;
  endtask

  function automatic int page_diffs(input int first, input int bytes);
    int n = 0;
    for (int i = first; i < first + bytes; i++) if (mem[i] != src[i]) n++;
    return n;
  endfunction

  initial begin
    bit got, seen;
    int tb, pb, n_seen;
    rst_n = 0; req_valid = 0; req_addr = 0; req_len = 0;
    corrupt_on = 0; stuck_on = 0; corrupt_page = 0;
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R12 reset busy", busy, 0);
    check_eq("R10 reset cs_n", spi_cs_n, 1);
    check_eq("R12 reset done", done, 0);

    tb = tx_n;
    run(24'h000010, 25'd256, got, seen);
    check_eq("R1 bad addr done", seen, 1);
    check_eq("R1 bad addr pass", got, 0);
    run(24'h000000, 25'h80, got, seen);
    check_eq("R1 bad len pass", got, 0);
    check_eq("R1 no transactions", tx_n - tb, 0);

    tb = tx_n;
    run(24'h000400, 25'd0, got, seen);
    check_eq("R2 zero len pass", got, 1);
    check_eq("R2 no transactions", tx_n - tb, 0);

    fill(1);
    tb = tx_n; pb = pp_n;
    run(24'h123400, 25'd256, got, seen);
    check_eq("R9 single pass", got, 1);
    check_eq("R5 tx count", tx_n - tb, 6);
    check_eq("R3 read op", log_cmd[tb], 8'h03);
    check_eq("R3 read addr", log_addr[tb], 24'h123400);
    check_eq("R3 read len", log_len[tb], 260);
    check_eq("R5 wren op", log_cmd[tb+1], 8'h06);
    check_eq("R5 wren len", log_len[tb+1], 1);
    check_eq("R5 wel poll op", log_cmd[tb+2], 8'h05);
    check_eq("R5 wel poll len", log_len[tb+2], 4);
    check_eq("R6 prog op", log_cmd[tb+3], 8'h02);
    check_eq("R6 prog addr", log_addr[tb+3], 24'h123400);
    check_eq("R6 prog len", log_len[tb+3], 260);
    check_eq("R7 wip poll len", log_len[tb+4], 5);
    check_eq("R7 verify op", log_cmd[tb+5], 8'h03);
    check_eq("R6 data", page_diffs(0, 256), 0);
    check_eq("R3 dummy bytes", dummy_bad, 0);

    tb = tx_n; pb = pp_n;
    run(24'h123400, 25'd256, got, seen);
    check_eq("R4 skip pass", got, 1);
    check_eq("R4 skip tx count", tx_n - tb, 1);
    check_eq("R4 skip no prog", pp_n - pb, 0);

    for (int n = 1; n <= 4; n++) begin
      for (int s = 0; s <= 4 - n; s++) begin
        fill(n * 5 + s + 2);
        pb = pp_n;
        run(24'(s * 256), 25'(n * 256), got, seen);
        check_eq("R9 sweep pass", got, 1);
        check_eq("R8 sweep prog count", pp_n - pb, n);
        for (int k = 0; k < n; k++)
          check_eq("R8 sweep order", pp_log[(pb + k) % 256], 24'((s + n - 1 - k) * 256));
        check_eq("R6 sweep data", page_diffs(s * 256, n * 256), 0);
      end
    end

    fill(40);
    run(24'h000000, 25'd1024, got, seen);
    check_eq("R9 full pass", got, 1);
    src[12'h211] ^= 8'h01;
    pb = pp_n;
    run(24'h000000, 25'd1024, got, seen);
    check_eq("R4 one page pass", got, 1);
    check_eq("R4 one page prog", pp_n - pb, 1);
    check_eq("R4 one page addr", pp_log[pb % 256], 24'h000200);

    fill(50);
    corrupt_on = 1; corrupt_page = 24'h000200;
    pb = pp_n;
    run(24'h000000, 25'd1024, got, seen);
    corrupt_on = 0;
    check_eq("R7 verify fail", got, 0);
    check_eq("R7 prog count", pp_n - pb, 2);
    check_eq("R7 first prog", pp_log[pb % 256], 24'h000300);
    n_seen = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != val(i, 40)) n_seen++;
    check_eq("R7 lower pages kept", n_seen, 0);

    fill(60);
    stuck_on = 1;
    tb = tx_n;
    run(24'h000300, 25'd256, got, seen);
    stuck_on = 0;
    check_eq("R11 timeout fail", got, 0);
    check_eq("R11 tx count", tx_n - tb, 5);
    check_eq("R11 poll bytes", log_len[(tb + 4) % 1024], 17);

    check_eq("R10 framing", frame_bad, 0);
    check_eq("R12 pulse width", pulse_bad, 0);
    check_eq("R12 busy at done", busy_bad, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule